// File: doc/BRIEF.md
# Two-Way Message FIFO Mailbox

This block carries 32-bit message words between a host register port and a processing engine. The host sees one data address. A write to it pushes a word into the inbound FIFO, toward the engine. A read from it pops a word from the outbound FIFO, from the engine. Beside the data address the host has four more registers:

- a status register that reports fill state and interrupt flags for every queue;
- a control register holding the FIFO enables;
- a mailbox register that the engine sets and the host clears with a key value;
- a watch FIFO that the engine fills with debug entries.

The engine side is a plain port: it pops the inbound FIFO, pushes the outbound FIFO, pushes watch entries and sets mailbox bits. A message is normally two words. The host checks that the inbound FIFO is empty before the first word and not full before the second. Each FIFO is two words deep.

Top module: `msg_mailbox`

## Requirements
- R1: A host write at word address 0 pushes the word into the inbound FIFO. The engine sees the oldest word on `eng_in_data` with `eng_in_valid` high, and each `eng_in_pop` advances to the next word in write order.
- R2: A host read at word address 0 returns the oldest outbound word and removes it. A read of an empty outbound FIFO returns 0 and changes nothing.
- R3: The inbound, outbound and watch FIFOs each hold two words. A push into a full FIFO is dropped and leaves the stored words unchanged.
- R4: The status register (word address 1) reports the fill state of the two message FIFOs:
  - bit 16: outbound not empty;
  - bit 17: inbound not full;
  - bit 18: outbound not full;
  - bit 19: inbound not empty.
- R5: The status register (word address 1) also reports four interrupt flags:
  - bit 20: the mailbox is nonzero;
  - bit 21: the inbound FIFO is enabled and not empty;
  - bit 22: the outbound FIFO is enabled and not empty;
  - bit 23: the watch FIFO is not empty.

  All other status bits read 0.
- R6: The control register (word address 2) stores only bits 16, 17, 24 and 25, and every other bit reads 0. The outbound FIFO is enabled by bit 16 or bit 24, and the inbound FIFO by bit 17 or bit 25. The enables affect only the interrupt flags.
- R7: The mailbox register (word address 3) ORs in `eng_mbox_bits` on each `eng_mbox_set`. A host write of 0x0000F0F0 clears it, and a host write of any other value leaves it unchanged.
- R8: A read at word address 4 pops one watch entry. The read returns bit 31 = 1 with the entry in bits 30:0, or 0 when the watch FIFO is empty.
- R9: After reset all FIFOs are empty, control and mailbox are 0, and status reads 0x00060000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Word address of the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the current address, valid in the access cycle |
| eng_in_pop | input | 1 | Engine removes the inbound head word |
| eng_in_data | output | 32 | Inbound head word, 0 when empty |
| eng_in_valid | output | 1 | Inbound FIFO holds a word |
| eng_out_push | input | 1 | Engine pushes a word into the outbound FIFO |
| eng_out_data | input | 32 | Outbound word to push |
| eng_out_ready | output | 1 | Outbound FIFO is not full |
| eng_wp_push | input | 1 | Engine pushes a watch entry |
| eng_wp_data | input | 31 | Watch entry payload |
| eng_mbox_set | input | 1 | Engine ORs bits into the mailbox |
| eng_mbox_bits | input | 32 | Bits to set in the mailbox |

## Verification
On every cycle the assertions check these properties:
- FIFO occupancy never exceeds two words.
- A push into a full FIFO or a pop from an empty FIFO leaves the occupancy unchanged.
- An empty data read returns zero.
- Reserved control bits read as zero.
- The mailbox clear key empties the mailbox.

Only the bench scenarios can show the rest: that words leave each FIFO in the order they entered, that a dropped push keeps the stored words intact, that interrupt flags follow the enables, and that watch reads pack the valid bit with the payload. The bench checks these against a reference model in long random sequences.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_MBOX = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_WTCH = 3'd4;

  localparam int unsigned ST_OUT_NE  = 16;
  localparam int unsigned ST_IN_NF   = 17;
  localparam int unsigned ST_OUT_NF  = 18;
  localparam int unsigned ST_IN_NE   = 19;
  localparam int unsigned ST_MB_INT  = 20;
  localparam int unsigned ST_IN_INT  = 21;
  localparam int unsigned ST_OUT_INT = 22;
  localparam int unsigned ST_WP_INT  = 23;

  localparam int unsigned CT_OUT_EN  = 16;
  localparam int unsigned CT_IN_EN   = 17;
  localparam int unsigned CT_OUT_WEN = 24;
  localparam int unsigned CT_IN_WEN  = 25;

  localparam logic [DATA_W-1:0] CTRL_MASK     = 32'h0303_0000;
  localparam logic [DATA_W-1:0] MBOX_CLR_KEY  = 32'h0000_F0F0;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             not_full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign push_ok = push && (cnt_q != FULL);
  assign pop_ok  = pop  && (cnt_q != '0);

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data;
  end

  assign not_empty = (cnt_q != '0);
  assign not_full  = (cnt_q != FULL);
  assign head      = not_empty ? mem_q[rd_q] : '0;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R3
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !not_full && !pop) |=> !not_full); // R3
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty && !push) |=> !not_empty); // R2
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_mbox_set,
  input  logic [DATA_W-1:0] eng_mbox_bits,
  input  logic [DATA_W-1:0] out_head,
  input  logic              out_ne,
  input  logic              out_nf,
  input  logic              in_ne,
  input  logic              in_nf,
  input  logic [DATA_W-2:0] wp_head,
  input  logic              wp_ne,
  output logic              in_push,
  output logic              out_pop,
  output logic              wp_pop
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, mbox_q, mbox_d, status;
  logic              wr_cyc, rd_cyc, ctrl_en, mbox_clr, out_en, in_en;

  assign wr_cyc   = host_sel && host_we;
  assign rd_cyc   = host_sel && !host_we;
  assign ctrl_en  = wr_cyc && (host_addr == OFS_CTRL);
  assign mbox_clr = wr_cyc && (host_addr == OFS_MBOX) && (host_wdata == MBOX_CLR_KEY);

  assign in_push  = wr_cyc && (host_addr == OFS_DATA);
  assign out_pop  = rd_cyc && (host_addr == OFS_DATA);
  assign wp_pop   = rd_cyc && (host_addr == OFS_WTCH);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = host_wdata & CTRL_MASK;
    mbox_d = mbox_clr ? '0 : mbox_q;
    if (eng_mbox_set) mbox_d = mbox_d | eng_mbox_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mbox_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mbox_q <= mbox_d;
    end
  end

  assign out_en = ctrl_q[CT_OUT_EN] | ctrl_q[CT_OUT_WEN];
  assign in_en  = ctrl_q[CT_IN_EN]  | ctrl_q[CT_IN_WEN];

  always_comb begin
    status             = '0;
    status[ST_OUT_NE]  = out_ne;
    status[ST_IN_NF]   = in_nf;
    status[ST_OUT_NF]  = out_nf;
    status[ST_IN_NE]   = in_ne;
    status[ST_MB_INT]  = |mbox_q;
    status[ST_IN_INT]  = in_en & in_ne;
    status[ST_OUT_INT] = out_en & out_ne;
    status[ST_WP_INT]  = wp_ne;
  end

  always_comb begin
    case (host_addr)
      OFS_DATA: host_rdata = out_head;
      OFS_STAT: host_rdata = status;
      OFS_CTRL: host_rdata = ctrl_q;
      OFS_MBOX: host_rdata = mbox_q;
      OFS_WTCH: host_rdata = {wp_ne, wp_head};
      default:  host_rdata = '0;
    endcase
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pop && !out_ne) |-> (host_rdata == '0)); // R2
  AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_CTRL) |-> ((host_rdata & ~CTRL_MASK) == '0)); // R6
  AST_MBOX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_clr && !eng_mbox_set) |=> (mbox_q == '0)); // R7
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        eng_in_pop,
  output logic [31:0] eng_in_data,
  output logic        eng_in_valid,
  input  logic        eng_out_push,
  input  logic [31:0] eng_out_data,
  output logic        eng_out_ready,
  input  logic        eng_wp_push,
  input  logic [30:0] eng_wp_data,
  input  logic        eng_mbox_set,
  input  logic [31:0] eng_mbox_bits
);
  logic              rst_ns;
  logic              in_push, out_pop, wp_pop;
  logic              in_ne, in_nf, out_ne, out_nf, wp_ne, wp_nf;
  logic [DATA_W-1:0] out_head;
  logic [DATA_W-2:0] wp_head;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  mbx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_ns), .push(in_push), .push_data(host_wdata),
    .pop(eng_in_pop), .head(eng_in_data), .not_empty(in_ne), .not_full(in_nf)
  );

  mbx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_ns), .push(eng_out_push), .push_data(eng_out_data),
    .pop(out_pop), .head(out_head), .not_empty(out_ne), .not_full(out_nf)
  );

  mbx_fifo #(.WIDTH(DATA_W-1), .DEPTH(FIFO_DEPTH)) u_wp_fifo (
    .clk(clk), .rst_n(rst_ns), .push(eng_wp_push), .push_data(eng_wp_data),
    .pop(wp_pop), .head(wp_head), .not_empty(wp_ne), .not_full(wp_nf)
  );

  mbx_regs u_regs (
    .clk(clk), .rst_n(rst_ns),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_mbox_set(eng_mbox_set), .eng_mbox_bits(eng_mbox_bits),
    .out_head(out_head), .out_ne(out_ne), .out_nf(out_nf),
    .in_ne(in_ne), .in_nf(in_nf), .wp_head(wp_head), .wp_ne(wp_ne),
    .in_push(in_push), .out_pop(out_pop), .wp_pop(wp_pop)
  );

  assign eng_in_valid  = in_ne;
  assign eng_out_ready = out_nf;

  AST_ENG_FLAGS: assert property (@(posedge clk) disable iff (!rst_ns)
    (eng_out_push && !eng_out_ready && !out_pop) |=> !eng_out_ready); // R3
  AST_WP_BOUND: assert property (@(posedge clk) disable iff (!rst_ns)
    (eng_wp_push && !wp_nf && !wp_pop) |=> !wp_nf); // R3
endmodule

// File: tb/msg_mailbox_test.sv
module msg_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_in_pop = 1'b0;
  logic [31:0] eng_in_data;
  logic        eng_in_valid;
  logic        eng_out_push = 1'b0;
  logic [31:0] eng_out_data = '0;
  logic        eng_out_ready;
  logic        eng_wp_push = 1'b0;
  logic [30:0] eng_wp_data = '0;
  logic        eng_mbox_set = 1'b0;
  logic [31:0] eng_mbox_bits = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] in_q [2];  int in_n = 0;
  logic [31:0] out_q [2]; int out_n = 0;
  logic [30:0] wp_q [2];  int wp_n = 0;
  logic [31:0] m_ctrl = '0, m_mbox = '0;

  always #4 clk = ~clk;

  msg_mailbox uut (.*);

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    logic oe = m_ctrl[16] | m_ctrl[24];
    logic ie = m_ctrl[17] | m_ctrl[25];
    s[16] = out_n != 0;  s[17] = in_n != 2;
    s[18] = out_n != 2;  s[19] = in_n != 0;
    s[20] = m_mbox != 0; s[21] = ie && in_n != 0;
    s[22] = oe && out_n != 0; s[23] = wp_n != 0;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host(input bit we, input logic [2:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    host_sel = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #1 rd = host_rdata;
    @(posedge clk);
    #1 host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic eng(input bit op, input logic [31:0] od, input bit ip,
                     input bit wpp, input logic [30:0] wd,
                     input bit ms, input logic [31:0] mb);
    @(negedge clk);
    eng_out_push = op; eng_out_data = od; eng_in_pop = ip;
    eng_wp_push = wpp; eng_wp_data = wd; eng_mbox_set = ms; eng_mbox_bits = mb;
    @(posedge clk);
    #1 eng_out_push = 0; eng_in_pop = 0; eng_wp_push = 0; eng_mbox_set = 0;
  endtask

  // model ops paired with stimulus and checks
  task automatic m_hwrite(input logic [31:0] d);
    logic [31:0] r;
    host(1'b1, 3'd0, d, r);
    if (in_n < 2) begin in_q[in_n] = d; in_n++; end
  endtask

  task automatic m_hread(input string req);
    logic [31:0] r;
    host(1'b0, 3'd0, 32'h0, r);
    chk(req, r, out_n != 0 ? out_q[0] : 32'h0);
    if (out_n != 0) begin out_q[0] = out_q[1]; out_n--; end
  endtask

  task automatic m_epush(input logic [31:0] d);
    eng(1'b1, d, 1'b0, 1'b0, '0, 1'b0, '0);
    if (out_n < 2) begin out_q[out_n] = d; out_n++; end
  endtask

  task automatic m_epop(input string req);
    @(negedge clk); #1;
    chk({req, " valid"}, {31'h0, eng_in_valid}, {31'h0, in_n != 0});
    chk({req, " data"}, eng_in_data, in_n != 0 ? in_q[0] : 32'h0);
    eng(1'b0, '0, 1'b1, 1'b0, '0, 1'b0, '0);
    if (in_n != 0) begin in_q[0] = in_q[1]; in_n--; end
  endtask

  task automatic m_wpush(input logic [30:0] d);
    eng(1'b0, '0, 1'b0, 1'b1, d, 1'b0, '0);
    if (wp_n < 2) begin wp_q[wp_n] = d; wp_n++; end
  endtask

  task automatic m_wread(input string req);
    logic [31:0] r;
    host(1'b0, 3'd4, 32'h0, r);
    chk(req, r, wp_n != 0 ? {1'b1, wp_q[0]} : 32'h0);
    if (wp_n != 0) begin wp_q[0] = wp_q[1]; wp_n--; end
  endtask

  task automatic m_status(input string req);
    logic [31:0] r;
    host(1'b0, 3'd1, 32'h0, r);
    chk(req, r, exp_status());
  endtask

  task automatic m_ctrl_wr(input logic [31:0] d);
    logic [31:0] r;
    host(1'b1, 3'd2, d, r);
    m_ctrl = d & 32'h0303_0000;
    host(1'b0, 3'd2, 32'h0, r);
    chk("R6 ctrl readback", r, m_ctrl);
  endtask

  task automatic m_mbox_wr(input logic [31:0] d);
    logic [31:0] r;
    host(1'b1, 3'd3, d, r);
    if (d == 32'h0000_F0F0) m_mbox = 0;
    host(1'b0, 3'd3, 32'h0, r);
    chk("R7 mailbox", r, m_mbox);
  endtask

  task automatic m_mset(input logic [31:0] b);
    eng(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, b);
    m_mbox |= b;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9 reset state
    host(1'b0, 3'd1, 0, r); chk("R9 reset status", r, 32'h0006_0000);
    host(1'b0, 3'd2, 0, r); chk("R9 reset ctrl", r, 32'h0);
    host(1'b0, 3'd3, 0, r); chk("R9 reset mailbox", r, 32'h0);
    m_hread("R2 empty read at reset");
    m_wread("R8 empty watch at reset");

    // R1/R3 inbound: two-word message then overflow attempt
    m_hwrite(32'hCAFE_0001);
    m_status("R4 inbound one word");
    m_hwrite(32'hCAFE_0002);
    m_hwrite(32'hDEAD_BEEF);
    m_status("R4 R3 inbound full");
    m_epop("R1 R3 first word");
    m_epop("R1 second word");
    m_epop("R1 empty inbound");

    // R2/R3 outbound
    m_epush(32'h1111_0000); m_epush(32'h2222_0000); m_epush(32'h3333_0000);
    chk("R3 outbound ready low when full", {31'h0, eng_out_ready}, 32'h0);
    m_status("R4 outbound full");
    m_hread("R2 R3 oldest word");
    m_hread("R2 second word");
    m_hread("R2 empty returns zero");

    // R6/R5 control and interrupt gating
    m_ctrl_wr(32'hFFFF_FFFF);
    m_ctrl_wr(32'h0100_0000);
    m_epush(32'h0000_00AA);
    m_hwrite(32'h0000_00BB);
    m_status("R5 out int via write-enable bit, in int off");
    m_ctrl_wr(32'h0002_0000);
    m_status("R5 in int on, out int off");
    m_hread("R2 drain"); m_epop("R1 drain");

    // R7 mailbox
    m_mset(32'h0000_0005);
    m_status("R5 mailbox int");
    m_mbox_wr(32'h1234_5678);
    m_mbox_wr(32'h0000_F0F0);

    // R8 watch FIFO
    m_wpush(31'h1234_5678); m_wpush(31'h7FFF_FFFF); m_wpush(31'h0000_0001);
    m_status("R5 watch int");
    m_wread("R8 first entry"); m_wread("R8 second entry"); m_wread("R8 empty");

    // random mix
    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 9))
        0: m_hwrite($urandom());
        1: m_hread("R2 random read");
        2: m_epush($urandom());
        3: m_epop("R1 random pop");
        4: m_wpush(31'($urandom()));
        5: m_wread("R8 random watch");
        6: m_status("R4 R5 random status");
        7: m_ctrl_wr($urandom());
        8: m_mset($urandom() & 32'h0000_0F0F);
        default: m_mbox_wr(($urandom_range(0, 1) != 0) ? 32'h0000_F0F0 : $urandom());
      endcase
    end
    m_status("R4 R5 final status");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule